// File: doc/BRIEF.md
# Interleaved PWM Phase Doubler

This block takes pre-decoded three-level PWM symbols (LOW, HIGH or TRISTATE) and turns them into per-channel gate commands (HIGH, LOW or OFF) for two buck power-stage channels. A downstream gate sequencer consumes those commands and handles dead time and drive. A strap input chooses the phase mode, and the block samples it while reset is held. In dual mode each command input drives its own channel. In doubler mode only the primary input is used. Its HIGH pulses are handed to the two channels in turn, so the channels run 180 degrees apart and each one switches at half the input pulse rate.

A TRISTATE on the primary input in doubler mode turns both channels off. When the input comes back out of TRISTATE, the block first drives only the 0-degree channel and holds the 180-degree channel off. This lets the regulator run single-phase at light load. Interleaving starts again on the next fresh LOW-to-HIGH edge. Every output is registered, so a symbol sampled at one rising clock edge appears on the outputs right after that edge.

Top module: `phase_doubler`

## Requirements
- R1: While rstN is low, both outputs are OFF (2'b00) after the next clock edge, and the steering returns to the 0-degree channel (outA), so the first doubler pulse after reset goes to outA.
- R2: The mode strap (1 = doubler, 0 = dual) is sampled on every clock edge while rstN is low. After rstN rises, changes on the strap have no effect on the outputs until the next reset.
- R3: In dual mode, each output follows its own input one clock later. Input codes are LOW = 2'b00, HIGH = 2'b01, TRISTATE = 2'b10 or 2'b11. Output codes are OFF = 2'b00, LOW = 2'b01, HIGH = 2'b10. LOW maps to LOW, HIGH to HIGH and TRISTATE to OFF. A TRISTATE on one input turns off only that input's channel.
- R4: In alternating doubler operation, each HIGH pulse on cmdA goes to one channel, starting with outA after reset. While the pulse lasts, the other channel is commanded LOW. While cmdA is LOW, both outputs are LOW.
- R5: The steering changes channel only when a steered HIGH pulse ends (HIGH followed by LOW), so a HIGH pulse that lasts several cycles stays on a single channel.
- R6: In doubler mode, cmdB has no effect on either output.
- R7: In doubler mode, a TRISTATE symbol on cmdA (code 2'b10 or 2'b11) makes both outputs OFF one clock later, whatever the steering state.
- R8: After cmdA leaves TRISTATE in doubler mode, outA follows cmdA (HIGH→HIGH, LOW→LOW) and outB stays OFF until a fresh LOW-to-HIGH edge arrives.
- R9: During that single-channel recovery, a LOW-to-HIGH edge on cmdA restarts alternating operation, and that first pulse goes to outB. Going straight from TRISTATE to HIGH does not count as such an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| modeStrap | input | 1 | Phase-mode strap: 1 doubler, 0 dual |
| cmdA | input | 2 | Primary PWM symbol |
| cmdB | input | 2 | Secondary PWM symbol (dual mode only) |
| outA | output | 2 | 0-degree channel gate command |
| outB | output | 2 | 180-degree channel gate command |

## Verification
Two doubler functions can meet in the same cycle. A TRISTATE can arrive exactly when a steered pulse would end, and the recovery edge can arrive in the very cycle that must also choose which channel gets the pulse. The bench sets up the first case by going straight from a HIGH on the 0-degree channel into TRISTATE. It then checks that both outputs are OFF and that the next recovery pulse stays on outA. It sets up the second case with a LOW-to-HIGH edge right after a recovery LOW, and with a second edge right after TRISTATE exits into LOW. In both cases the resumed pulse must appear on outB while outA shows LOW in that same cycle.

// File: rtl/phdbl_pkg.sv
package phdbl_pkg;

  localparam int SYM_W  = 2;
  localparam int GATE_W = 2;
  localparam int NUM_CH = 2;

  typedef enum logic [SYM_W-1:0] {
    SYM_LOW  = 2'b00,
    SYM_HIGH = 2'b01,
    SYM_TRI  = 2'b10,
    SYM_TRIX = 2'b11
  } sym_e;

  typedef enum logic [GATE_W-1:0] {
    GATE_OFF  = 2'b00,
    GATE_LOW  = 2'b01,
    GATE_HIGH = 2'b10
  } gate_e;

  typedef enum logic [2:0] {
    SEL_OFF,
    SEL_LOW,
    SEL_HIGH,
    SEL_PRI,
    SEL_SEC
  } chanSel_e;

  typedef enum logic [1:0] {
    SEQ_ALT,
    SEQ_TRI,
    SEQ_SINGLE
  } seq_e;

  typedef struct packed {
    chanSel_e selA;
    chanSel_e selB;
  } steerStrobe_t;

  function automatic gate_e symToGate(input logic [SYM_W-1:0] s);
    if (s[1])           return GATE_OFF;
    else if (s == 2'b01) return GATE_HIGH;
    else                return GATE_LOW;
  endfunction

endpackage

// File: rtl/phdbl_ctrl.sv
module phdbl_ctrl
  import phdbl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeStrap,
  input  logic [SYM_W-1:0] symPri,
  output steerStrobe_t     strobe,
  output logic             doublerMode
);

  seq_e             seqQ, seqNext;
  logic             steerQ, steerNext;
  logic [SYM_W-1:0] prevQ;
  logic             doublerQ;

  logic priTri, priHigh, priLow, prevHigh, prevLow;

  assign priTri   = symPri[1];
  assign priHigh  = (symPri == 2'b01);
  assign priLow   = (symPri == 2'b00);
  assign prevHigh = (prevQ == 2'b01);
  assign prevLow  = (prevQ == 2'b00);

  always_comb begin
    strobe.selA = SEL_OFF;
    strobe.selB = SEL_OFF;
    seqNext     = seqQ;
    steerNext   = steerQ;
    if (!doublerQ) begin
      strobe.selA = SEL_PRI;
      strobe.selB = SEL_SEC;
    end else if (priTri) begin
      seqNext = SEQ_TRI;
    end else begin
      case (seqQ)
        SEQ_TRI: begin
          strobe.selA = SEL_PRI;
          seqNext     = SEQ_SINGLE;
          steerNext   = 1'b1;
        end
        SEQ_SINGLE: begin
          if (prevLow && priHigh) begin
            seqNext     = SEQ_ALT;
            strobe.selA = steerQ ? SEL_LOW  : SEL_HIGH;
            strobe.selB = steerQ ? SEL_HIGH : SEL_LOW;
          end else begin
            strobe.selA = SEL_PRI;
          end
        end
        default: begin
          if (priHigh) begin
            strobe.selA = steerQ ? SEL_LOW  : SEL_HIGH;
            strobe.selB = steerQ ? SEL_HIGH : SEL_LOW;
          end else begin
            strobe.selA = SEL_LOW;
            strobe.selB = SEL_LOW;
          end
          if (prevHigh && priLow) steerNext = ~steerQ;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqQ     <= SEQ_ALT;
      steerQ   <= 1'b0;
      prevQ    <= 2'b00;
      doublerQ <= modeStrap;
    end else begin
      seqQ   <= seqNext;
      steerQ <= steerNext;
      prevQ  <= symPri;
    end
  end

  assign doublerMode = doublerQ;

endmodule

// File: rtl/phdbl_datapath.sv
module phdbl_datapath
  import phdbl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SYM_W-1:0]  symPri,
  input  logic [SYM_W-1:0]  symSec,
  input  steerStrobe_t      strobe,
  output logic [GATE_W-1:0] outA,
  output logic [GATE_W-1:0] outB
);

  gate_e gateQ [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    chanSel_e sel;
    gate_e    gateNext;

    assign sel = (ch == 0) ? strobe.selA : strobe.selB;

    always_comb begin
      case (sel)
        SEL_LOW:  gateNext = GATE_LOW;
        SEL_HIGH: gateNext = GATE_HIGH;
        SEL_PRI:  gateNext = symToGate(symPri);
        SEL_SEC:  gateNext = symToGate(symSec);
        default:  gateNext = GATE_OFF;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) gateQ[ch] <= GATE_OFF;
      else       gateQ[ch] <= gateNext;
    end
  end

  assign outA = gateQ[0];
  assign outB = gateQ[1];

endmodule

// File: rtl/phase_doubler.sv
module phase_doubler
  import phdbl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeStrap,
  input  logic [1:0] cmdA,
  input  logic [1:0] cmdB,
  output logic [1:0] outA,
  output logic [1:0] outB
);

  steerStrobe_t strobe;
  logic         doublerMode;

  phdbl_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .modeStrap   (modeStrap),
    .symPri      (cmdA),
    .strobe      (strobe),
    .doublerMode (doublerMode)
  );

  phdbl_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .symPri (cmdA),
    .symSec (cmdB),
    .strobe (strobe),
    .outA   (outA),
    .outB   (outB)
  );

endmodule

// File: rtl/phdbl_checker.sv
module phdbl_checker (
  input logic       clk,
  input logic       rstN,
  input logic       doublerMode,
  input logic [1:0] cmdA,
  input logic [1:0] cmdB,
  input logic [1:0] outA,
  input logic [1:0] outB
);

  // R1
  reset_off_chk: assert property (@(posedge clk)
    !rstN |=> (outA == 2'b00 && outB == 2'b00));

  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(doublerMode));

  // R3
  dual_tri_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!doublerMode && cmdB[1]) |=> (outB == 2'b00));

  // R3
  dual_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!doublerMode && cmdA == 2'b01) |=> (outA == 2'b10));

  // R4
  no_double_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    doublerMode |-> !(outA == 2'b10 && outB == 2'b10));

  // R7
  dbl_tri_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doublerMode && cmdA[1]) |=> (outA == 2'b00 && outB == 2'b00));

endmodule

bind phase_doubler phdbl_checker chk (
  .clk         (clk),
  .rstN        (rstN),
  .doublerMode (doublerMode),
  .cmdA        (cmdA),
  .cmdB        (cmdB),
  .outA        (outA),
  .outB        (outB)
);

// File: tb/phase_doubler_test.sv
module phase_doubler_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeStrap = 1'b1;
  logic [1:0] cmdA = 2'b00;
  logic [1:0] cmdB = 2'b00;
  logic [1:0] outA, outB;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  phase_doubler uut (
    .clk(clk), .rstN(rstN), .modeStrap(modeStrap),
    .cmdA(cmdA), .cmdB(cmdB), .outA(outA), .outB(outB)
  );

  // inputs L=00 H=01 T=10/11 ; outputs OFF=00 LOW=01 HIGH=10
  // entry: {cmdA, cmdB, expA, expB, requirement number}
  localparam int NVEC = 18;
  localparam logic [11:0] VEC [NVEC] = '{
    {2'b00, 2'b01, 2'b01, 2'b01, 4'd6},  // R6 cmdB HIGH ignored
    {2'b01, 2'b10, 2'b10, 2'b01, 4'd4},  // R4 first pulse to outA
    {2'b01, 2'b01, 2'b10, 2'b01, 4'd5},  // R5 long pulse stays
    {2'b00, 2'b00, 2'b01, 2'b01, 4'd4},
    {2'b01, 2'b00, 2'b01, 2'b10, 4'd4},  // R4 second pulse to outB
    {2'b00, 2'b01, 2'b01, 2'b01, 4'd4},
    {2'b01, 2'b00, 2'b10, 2'b01, 4'd4},
    {2'b10, 2'b01, 2'b00, 2'b00, 4'd7},  // R7 tri on pulse end
    {2'b01, 2'b00, 2'b10, 2'b00, 4'd8},  // R8 exit into HIGH
    {2'b01, 2'b01, 2'b10, 2'b00, 4'd8},
    {2'b00, 2'b00, 2'b01, 2'b00, 4'd8},
    {2'b01, 2'b10, 2'b01, 2'b10, 4'd9},  // R9 fresh edge to outB
    {2'b00, 2'b00, 2'b01, 2'b01, 4'd4},
    {2'b01, 2'b00, 2'b10, 2'b01, 4'd4},
    {2'b11, 2'b00, 2'b00, 2'b00, 4'd7},  // R7 code 11
    {2'b00, 2'b01, 2'b01, 2'b00, 4'd8},  // R8 exit into LOW
    {2'b01, 2'b00, 2'b01, 2'b10, 4'd9},  // R9
    {2'b00, 2'b00, 2'b01, 2'b01, 4'd4}
  };

  task automatic check(input logic [1:0] ea, input logic [1:0] eb, input int req);
    checks++;
    if (outA !== ea || outB !== eb) begin
      failures++;
      $display("FAIL R%0d outA=%b outB=%b expected outA=%b outB=%b", req, outA, outB, ea, eb);
    end
  endtask

  task automatic step(input logic [1:0] a, input logic [1:0] b,
                      input logic [1:0] ea, input logic [1:0] eb, input int req);
    cmdA = a;
    cmdB = b;
    @(negedge clk);
    check(ea, eb, req);
  endtask

  task automatic doReset(input logic strap);
    rstN = 1'b0;
    modeStrap = strap;
    cmdA = 2'b01;
    cmdB = 2'b01;
    repeat (3) @(negedge clk);
    check(2'b00, 2'b00, 1);  // R1 outputs OFF in reset
    rstN = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset(1'b1);
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][11:10], VEC[i][9:8], VEC[i][7:6], VEC[i][5:4], int'(VEC[i][3:0]));
    end

    // R2: strap flips mid-run, doubler behaviour stays
    modeStrap = 1'b0;
    step(2'b01, 2'b01, 2'b10, 2'b01, 2);
    step(2'b00, 2'b01, 2'b01, 2'b01, 2);

    // R1: reset mid-run returns steering to outA
    step(2'b01, 2'b00, 2'b01, 2'b10, 4);
    step(2'b00, 2'b00, 2'b01, 2'b01, 4);
    doReset(1'b1);
    step(2'b01, 2'b00, 2'b10, 2'b01, 1);

    // R3: dual mode pass-through
    doReset(1'b0);
    step(2'b01, 2'b00, 2'b10, 2'b01, 3);
    step(2'b10, 2'b01, 2'b00, 2'b10, 3);
    step(2'b00, 2'b10, 2'b01, 2'b00, 3);
    step(2'b11, 2'b01, 2'b00, 2'b10, 3);
    // R2: strap raised after reset, dual stays
    modeStrap = 1'b1;
    step(2'b01, 2'b01, 2'b10, 2'b10, 2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule